// File: doc/BRIEF.md
# ATA Device Task-File Register Block

This block is the device-side register file of a parallel ATA style disk interface. A host reaches eight byte-wide registers through a 3-bit address with separate read and write strobes. The registers are a data port, an error/features pair, a sector count, three address bytes, a drive/head byte and a status/command pair. Offsets 1 and 7 are split: a read returns one register and a write loads another. The block presents the address bytes either as a 28-bit logical block address or as cylinder/head/sector values, depending on the mode bit in the drive/head byte.

Writing the command offset decodes the opcode into a protocol class and either hands the command to a backend or aborts it locally. The backend stands in for the drive. It sees a one-cycle start pulse together with the opcode and the class. It answers with a done pulse, which may be flagged as a failure. For PIO classes it also reports when the last word of the transfer has moved. Host writes to the data offset are forwarded as a byte pulse. Host reads of the data offset return the backend's byte.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset, status (offset 7) reads 50h, drive/head (offset 6) reads A0h, and offsets 1 to 5 read 00h.
- R2: Offsets 2, 3, 4 and 5 read back the last byte written to them. A write to offset 1 appears on `features`, while a read of offset 1 returns the error register.
- R3: Drive/head reads with bits 7 and 5 at 1. Bit 6 is the LBA mode flag (1 = LBA), bit 4 is the drive select and bits 3..0 are the head; these bits read back as written.
- R4: In LBA mode `lba_addr` = {drive/head[3:0], offset 5, offset 4, offset 3} and the CHS outputs are zero. In CHS mode `chs_cyl` = {offset 5, offset 4}, `chs_head` = drive/head[3:0], `chs_sector` = offset 3 and `lba_addr` is zero.
- R5: The status bits are 7 busy, 6 ready, 5 write fault, 4 seek complete, 3 data request, 2 corrected, 1 index and 0 error; ready and seek complete read 1, and write fault, corrected and index read 0. A command write sets busy and clears error at the same edge, so status reads D0h.
- R6: A decoded command raises `cmd_start` for exactly one cycle, starting at the write edge. During that cycle `cmd_opcode` holds the opcode and `cmd_class` holds the class (0 non-data, 1 PIO-in, 2 PIO-out, 3 DMA). The PIO-in opcodes are 20h-23h, C4h and ECh. The PIO-out opcodes are 30h-33h and C5h. The DMA opcodes are C8h-CBh. The non-data opcodes are 00h, 1xh, 40h, 41h, 7xh, 90h, 91h and EFh.
- R7: Opcode B0h is decoded as non-data only when offset 4 holds 4Fh and offset 5 holds C2h; otherwise it aborts.
- R8: An opcode that is not decoded never raises `cmd_start`. One cycle after the write, busy clears and status reads 51h, and the error register reads 04h (bit 2, abort).
- R9: Busy stays set until `be_done`. At done, busy clears; if `be_fail` is high at that time, status bit 0 and error bit 2 are also set.
- R10: After a successful PIO-class command, done sets data request (status 58h). The request clears on `be_last_word`. Non-data and DMA commands never set it.
- R11: While busy, host writes to offsets 0 to 7 have no effect and reads of any offset return the status byte.
- R12: When not busy, a write to offset 0 gives a one-cycle `dp_wr` pulse, registered at that edge, with the byte on `dp_wdata`. A read of offset 0 returns `dp_rdata` and drives `dp_rd` while `host_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe (used for the data port pulse) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the addressed offset |
| dp_wr | output | 1 | Data port write pulse |
| dp_wdata | output | 8 | Data port write byte |
| dp_rd | output | 1 | Data port read indication |
| dp_rdata | input | 8 | Data port byte from the backend |
| features | output | 8 | Features register |
| sect_count | output | 8 | Sector count register |
| lba_mode | output | 1 | Drive/head LBA mode flag |
| drive_sel | output | 1 | Drive select |
| lba_addr | output | 28 | Logical block address (zero in CHS mode) |
| chs_cyl | output | 16 | Cylinder (zero in LBA mode) |
| chs_head | output | 4 | Head (zero in LBA mode) |
| chs_sector | output | 8 | Sector number (zero in LBA mode) |
| cmd_start | output | 1 | One-cycle command start to the backend |
| cmd_opcode | output | 8 | Last accepted opcode |
| cmd_class | output | 2 | Protocol class of the last opcode |
| be_done | input | 1 | Backend completion pulse |
| be_fail | input | 1 | Backend completion failed (abort) |
| be_last_word | input | 1 | Last PIO word has moved |

## Verification
On every cycle, the assertions check the following. The start pulse lasts one cycle and is only seen while busy. Busy and data request are never high together. A completion while busy clears busy. A command write sets busy with error clear. The fixed-one drive/head bits read as 1. A busy read has bit 7 set. The sector count does not change while writes arrive during busy. Only the bench's scenarios can show the rest: the per-opcode classification, the SMART signature check, the exact status and error bytes after aborts and backend failures, the LBA and CHS address layouts, and the data-request timing of the PIO classes.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned LBA_W  = 28;
  localparam int unsigned HEAD_W = 4;

  localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_FEAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_SCNT = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_SECN = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_CYLL = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_CYLH = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_DRHD = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 3'd7;

  localparam logic [REG_W-1:0] SMART_KEY_LO = 8'h4F;
  localparam logic [REG_W-1:0] SMART_KEY_HI = 8'hC2;

  typedef enum logic [1:0] {
    CLS_NONDATA = 2'd0,
    CLS_PIO_IN  = 2'd1,
    CLS_PIO_OUT = 2'd2,
    CLS_DMA     = 2'd3
  } cmd_class_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXEC  = 2'd1,
    ST_ABORT = 2'd2
  } tf_state_e;
endpackage

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode
  import ata_tf_pkg::*;
(
  input  logic [REG_W-1:0] opcode,
  input  logic [REG_W-1:0] key_lo,
  input  logic [REG_W-1:0] key_hi,
  output logic             known,
  output cmd_class_e       cls
);
  logic smart_key_ok;

  assign smart_key_ok = (key_lo == SMART_KEY_LO) && (key_hi == SMART_KEY_HI);

  always_comb begin
    known = 1'b1;
    cls   = CLS_NONDATA;
    casez (opcode)
      8'h00, 8'h1?, 8'h40, 8'h41,
      8'h7?, 8'h90, 8'h91, 8'hEF: cls = CLS_NONDATA;
      8'b0010_00??, 8'hC4, 8'hEC: cls = CLS_PIO_IN;
      8'b0011_00??, 8'hC5:        cls = CLS_PIO_OUT;
      8'b1100_10??:               cls = CLS_DMA;
      8'hB0: begin
        cls   = CLS_NONDATA;
        known = smart_key_ok;
      end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/ata_addr_fmt.sv
module ata_addr_fmt
  import ata_tf_pkg::*;
(
  input  logic              lba_sel,
  input  logic [HEAD_W-1:0] head_nib,
  input  logic [REG_W-1:0]  sec_b,
  input  logic [REG_W-1:0]  cyl_lo_b,
  input  logic [REG_W-1:0]  cyl_hi_b,
  output logic [LBA_W-1:0]  lba,
  output logic [2*REG_W-1:0] cyl,
  output logic [HEAD_W-1:0] head,
  output logic [REG_W-1:0]  sector
);
  always_comb begin
    if (lba_sel) begin
      lba    = {head_nib, cyl_hi_b, cyl_lo_b, sec_b};
      cyl    = '0;
      head   = '0;
      sector = '0;
    end else begin
      lba    = '0;
      cyl    = {cyl_hi_b, cyl_lo_b};
      head   = head_nib;
      sector = sec_b;
    end
  end
endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic cmd_known,
  input  logic cmd_pio,
  input  logic be_done,
  input  logic be_fail,
  input  logic be_last_word,
  output logic busy,
  output logic drq,
  output logic err,
  output logic abrt,
  output logic start
);
  tf_state_e st_q, st_d;
  logic busy_d, drq_d, err_d, abrt_d, start_d, pio_q, pio_d;

  always_comb begin
    st_d    = st_q;
    busy_d  = busy;
    drq_d   = drq;
    err_d   = err;
    abrt_d  = abrt;
    start_d = 1'b0;
    pio_d   = pio_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          busy_d = 1'b1;
          err_d  = 1'b0;
          abrt_d = 1'b0;
          drq_d  = 1'b0;
          pio_d  = cmd_pio;
          if (cmd_known) begin
            st_d    = ST_EXEC;
            start_d = 1'b1;
          end else begin
            st_d = ST_ABORT;
          end
        end else if (drq && be_last_word) begin
          drq_d = 1'b0;
        end
      end
      ST_ABORT: begin
        st_d   = ST_IDLE;
        busy_d = 1'b0;
        err_d  = 1'b1;
        abrt_d = 1'b1;
      end
      ST_EXEC: begin
        if (be_done) begin
          st_d   = ST_IDLE;
          busy_d = 1'b0;
          if (be_fail) begin
            err_d  = 1'b1;
            abrt_d = 1'b1;
          end else begin
            drq_d = pio_q;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      busy  <= 1'b0;
      drq   <= 1'b0;
      err   <= 1'b0;
      abrt  <= 1'b0;
      start <= 1'b0;
      pio_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      busy  <= busy_d;
      drq   <= drq_d;
      err   <= err_d;
      abrt  <= abrt_d;
      start <= start_d;
      pio_q <= pio_d;
    end
  end
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
  import ata_tf_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [REG_W-1:0]   host_wdata,
  output logic [REG_W-1:0]   host_rdata,
  output logic               dp_wr,
  output logic [REG_W-1:0]   dp_wdata,
  output logic               dp_rd,
  input  logic [REG_W-1:0]   dp_rdata,
  output logic [REG_W-1:0]   features,
  output logic [REG_W-1:0]   sect_count,
  output logic               lba_mode,
  output logic               drive_sel,
  output logic [LBA_W-1:0]   lba_addr,
  output logic [2*REG_W-1:0] chs_cyl,
  output logic [HEAD_W-1:0]  chs_head,
  output logic [REG_W-1:0]   chs_sector,
  output logic               cmd_start,
  output logic [REG_W-1:0]   cmd_opcode,
  output logic [1:0]         cmd_class,
  input  logic               be_done,
  input  logic               be_fail,
  input  logic               be_last_word
);
  localparam int unsigned SYNC_MSB = RST_SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rs_q;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_sync_n = rs_q[SYNC_MSB];

  logic busy_w, drq_w, err_w, abrt_w;
  logic wr_ok, cmd_wr, dec_known;
  cmd_class_e dec_cls;

  logic [REG_W-1:0]  feat_q, scnt_q, secn_q, cyll_q, cylh_q, cmd_q, dpw_q;
  logic [REG_W-1:0]  feat_d, scnt_d, secn_d, cyll_d, cylh_d, cmd_d;
  logic              lba_q, drv_q, lba_d, drv_d, dpw_stb_q;
  logic [HEAD_W-1:0] head_q, head_d;
  cmd_class_e        cls_q, cls_d;
  logic [REG_W-1:0]  status_b, error_b, drhd_b;

  assign wr_ok  = host_wr && !busy_w;
  assign cmd_wr = wr_ok && (host_addr == OFF_CMD);

  ata_cmd_decode u_dec (
    .opcode (host_wdata),
    .key_lo (cyll_q),
    .key_hi (cylh_q),
    .known  (dec_known),
    .cls    (dec_cls)
  );

  ata_tf_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cmd_wr       (cmd_wr),
    .cmd_known    (dec_known),
    .cmd_pio      ((dec_cls == CLS_PIO_IN) || (dec_cls == CLS_PIO_OUT)),
    .be_done      (be_done),
    .be_fail      (be_fail),
    .be_last_word (be_last_word),
    .busy         (busy_w),
    .drq          (drq_w),
    .err          (err_w),
    .abrt         (abrt_w),
    .start        (cmd_start)
  );

  ata_addr_fmt u_fmt (
    .lba_sel  (lba_q),
    .head_nib (head_q),
    .sec_b    (secn_q),
    .cyl_lo_b (cyll_q),
    .cyl_hi_b (cylh_q),
    .lba      (lba_addr),
    .cyl      (chs_cyl),
    .head     (chs_head),
    .sector   (chs_sector)
  );

  always_comb begin
    feat_d = feat_q;
    scnt_d = scnt_q;
    secn_d = secn_q;
    cyll_d = cyll_q;
    cylh_d = cylh_q;
    lba_d  = lba_q;
    drv_d  = drv_q;
    head_d = head_q;
    cmd_d  = cmd_q;
    cls_d  = cls_q;
    if (wr_ok) begin
      unique case (host_addr)
        OFF_FEAT: feat_d = host_wdata;
        OFF_SCNT: scnt_d = host_wdata;
        OFF_SECN: secn_d = host_wdata;
        OFF_CYLL: cyll_d = host_wdata;
        OFF_CYLH: cylh_d = host_wdata;
        OFF_DRHD: begin
          lba_d  = host_wdata[6];
          drv_d  = host_wdata[4];
          head_d = host_wdata[HEAD_W-1:0];
        end
        OFF_CMD: begin
          cmd_d = host_wdata;
          cls_d = dec_cls;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      feat_q    <= '0;
      scnt_q    <= '0;
      secn_q    <= '0;
      cyll_q    <= '0;
      cylh_q    <= '0;
      lba_q     <= 1'b0;
      drv_q     <= 1'b0;
      head_q    <= '0;
      cmd_q     <= '0;
      cls_q     <= CLS_NONDATA;
      dpw_q     <= '0;
      dpw_stb_q <= 1'b0;
    end else begin
      feat_q    <= feat_d;
      scnt_q    <= scnt_d;
      secn_q    <= secn_d;
      cyll_q    <= cyll_d;
      cylh_q    <= cylh_d;
      lba_q     <= lba_d;
      drv_q     <= drv_d;
      head_q    <= head_d;
      cmd_q     <= cmd_d;
      cls_q     <= cls_d;
      dpw_stb_q <= wr_ok && (host_addr == OFF_DATA);
      if (wr_ok && (host_addr == OFF_DATA)) dpw_q <= host_wdata;
    end
  end

  assign status_b = {busy_w, 1'b1, 1'b0, 1'b1, drq_w, 1'b0, 1'b0, err_w};
  assign error_b  = {5'b0, abrt_w, 2'b0};
  assign drhd_b   = {1'b1, lba_q, 1'b1, drv_q, head_q};

  always_comb begin
    if (busy_w) begin
      host_rdata = status_b;
    end else begin
      unique case (host_addr)
        OFF_DATA: host_rdata = dp_rdata;
        OFF_FEAT: host_rdata = error_b;
        OFF_SCNT: host_rdata = scnt_q;
        OFF_SECN: host_rdata = secn_q;
        OFF_CYLL: host_rdata = cyll_q;
        OFF_CYLH: host_rdata = cylh_q;
        OFF_DRHD: host_rdata = drhd_b;
        default:  host_rdata = status_b;
      endcase
    end
  end

  assign dp_rd      = host_rd && !busy_w && (host_addr == OFF_DATA);
  assign dp_wr      = dpw_stb_q;
  assign dp_wdata   = dpw_q;
  assign features   = feat_q;
  assign sect_count = scnt_q;
  assign lba_mode   = lba_q;
  assign drive_sel  = drv_q;
  assign cmd_opcode = cmd_q;
  assign cmd_class  = cls_q;
endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker
  import ata_tf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic [REG_W-1:0]  host_rdata,
  input logic [REG_W-1:0]  sect_count,
  input logic              busy,
  input logic              drq,
  input logic              err,
  input logic              cmd_start,
  input logic              be_done
);
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> busy);

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && be_done) |=> !busy);

  assert_no_drq_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && drq));

  assert_cmd_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !busy && host_addr == OFF_CMD) |=> (busy && !err));

  assert_drhd_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_addr == OFF_DRHD) |-> (host_rdata[7] && host_rdata[5]));

  assert_busy_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> host_rdata[7]);

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr) |=> $stable(sect_count));
endmodule

bind ata_taskfile_regs ata_tf_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rdata (host_rdata),
  .sect_count (sect_count),
  .busy       (busy_w),
  .drq        (drq_w),
  .err        (err_w),
  .cmd_start  (cmd_start),
  .be_done    (be_done)
);

// File: tb/ata_taskfile_regs_tb.sv
module ata_taskfile_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0, host_rdata;
  logic        dp_wr, dp_rd;
  logic [7:0]  dp_wdata, dp_rdata = 8'h3C;
  logic [7:0]  features, sect_count, chs_sector, cmd_opcode;
  logic        lba_mode, drive_sel, cmd_start;
  logic [27:0] lba_addr;
  logic [15:0] chs_cyl;
  logic [3:0]  chs_head;
  logic [1:0]  cmd_class;
  logic        be_done = 1'b0, be_fail = 1'b0, be_last_word = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ata_taskfile_regs u_dut (.*);

  // {opcode, cyl_lo, cyl_hi, known, class}
  localparam int NV = 23;
  localparam logic [26:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 1'b1, 2'd0}, {8'h13, 8'h00, 8'h00, 1'b1, 2'd0},
    {8'h20, 8'h00, 8'h00, 1'b1, 2'd1}, {8'h23, 8'h00, 8'h00, 1'b1, 2'd1},
    {8'h30, 8'h00, 8'h00, 1'b1, 2'd2}, {8'h33, 8'h00, 8'h00, 1'b1, 2'd2},
    {8'h40, 8'h00, 8'h00, 1'b1, 2'd0}, {8'h41, 8'h00, 8'h00, 1'b1, 2'd0},
    {8'h7A, 8'h00, 8'h00, 1'b1, 2'd0}, {8'h90, 8'h00, 8'h00, 1'b1, 2'd0},
    {8'h91, 8'h00, 8'h00, 1'b1, 2'd0}, {8'hC4, 8'h00, 8'h00, 1'b1, 2'd1},
    {8'hC5, 8'h00, 8'h00, 1'b1, 2'd2}, {8'hC8, 8'h00, 8'h00, 1'b1, 2'd3},
    {8'hCB, 8'h00, 8'h00, 1'b1, 2'd3}, {8'hEC, 8'h00, 8'h00, 1'b1, 2'd1},
    {8'hEF, 8'h00, 8'h00, 1'b1, 2'd0}, {8'hB0, 8'h4F, 8'hC2, 1'b1, 2'd0},
    {8'hB0, 8'h4F, 8'hC3, 1'b0, 2'd0}, {8'h24, 8'h00, 8'h00, 1'b0, 2'd0},
    {8'h42, 8'h00, 8'h00, 1'b0, 2'd0}, {8'hFF, 8'h00, 8'h00, 1'b0, 2'd0},
    {8'hC6, 8'h00, 8'h00, 1'b0, 2'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic finish_cmd(input logic fail);
    @(negedge clk);
    be_done = 1'b1; be_fail = fail;
    @(negedge clk);
    be_done = 1'b0; be_fail = 1'b0;
  endtask

  task automatic last_word();
    @(negedge clk);
    be_last_word = 1'b1;
    @(negedge clk);
    be_last_word = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    bus_rd(3'd7, r); check("R1 status", r, 8'h50);
    bus_rd(3'd6, r); check("R1 drive/head", r, 8'hA0);
    for (int a = 1; a <= 5; a++) begin
      bus_rd(a[2:0], r); check("R1 offset zero", r, 8'h00);
    end

    // R2 readback and split offset 1
    bus_wr(3'd2, 8'h08); bus_wr(3'd3, 8'h11); bus_wr(3'd4, 8'h22); bus_wr(3'd5, 8'h33);
    bus_wr(3'd1, 8'h9C);
    bus_rd(3'd2, r); check("R2 sector count", r, 8'h08);
    bus_rd(3'd3, r); check("R2 sector", r, 8'h11);
    bus_rd(3'd4, r); check("R2 cyl low", r, 8'h22);
    bus_rd(3'd5, r); check("R2 cyl high", r, 8'h33);
    check("R2 features out", features, 8'h9C);
    bus_rd(3'd1, r); check("R2 error on read", r, 8'h00);

    // R3 / R4 LBA mode
    bus_wr(3'd6, 8'h45);
    bus_rd(3'd6, r); check("R3 drive/head lba", r, 8'hE5);
    check("R4 lba addr", lba_addr, 28'h5332211);
    check("R4 chs zero in lba", {chs_cyl, chs_head, chs_sector}, 0);
    check("R3 lba flag", lba_mode, 1'b1);
    // R3 / R4 CHS mode
    bus_wr(3'd6, 8'h1A);
    bus_rd(3'd6, r); check("R3 drive/head chs", r, 8'hBA);
    check("R3 drive select", drive_sel, 1'b1);
    check("R4 chs cyl", chs_cyl, 16'h3322);
    check("R4 chs head", chs_head, 4'hA);
    check("R4 chs sector", chs_sector, 8'h11);
    check("R4 lba zero in chs", lba_addr, 28'h0);

    // R12 data port
    bus_wr(3'd0, 8'h5A);
    check("R12 dp_wr pulse", dp_wr, 1'b1);
    check("R12 dp_wdata", dp_wdata, 8'h5A);
    @(negedge clk);
    check("R12 dp_wr single", dp_wr, 1'b0);
    host_rd = 1'b1;
    bus_rd(3'd0, r); check("R12 data read", r, 8'h3C);
    check("R12 dp_rd", dp_rd, 1'b1);
    host_rd = 1'b0;

    // R5..R10 classification table
    for (int i = 0; i < NV; i++) begin
      logic [7:0] op, lo, hi;
      logic ok;
      logic [1:0] cls;
      {op, lo, hi, ok, cls} = VEC[i];
      bus_wr(3'd4, lo);
      bus_wr(3'd5, hi);
      bus_wr(3'd7, op);
      bus_rd(3'd7, r); check($sformatf("R5 busy after %0h", op), r, 8'hD0);
      if (ok) begin
        check($sformatf("R6 start %0h", op), cmd_start, 1'b1);
        check($sformatf("R6 class %0h", op), cmd_class, cls);
        check($sformatf("R6 opcode %0h", op), cmd_opcode, op);
        @(negedge clk);
        check($sformatf("R6 start ends %0h", op), cmd_start, 1'b0);
        bus_rd(3'd7, r); check($sformatf("R9 still busy %0h", op), r, 8'hD0);
        finish_cmd(1'b0);
        bus_rd(3'd7, r);
        if (cls == 2'd1 || cls == 2'd2) begin
          check($sformatf("R10 drq set %0h", op), r, 8'h58);
          last_word();
          bus_rd(3'd7, r); check($sformatf("R10 drq clear %0h", op), r, 8'h50);
        end else begin
          check($sformatf("R10 no drq %0h", op), r, 8'h50);
        end
      end else begin
        check($sformatf("R8 no start %0h", op), cmd_start, 1'b0);
        @(negedge clk);
        check($sformatf("R8 no start later %0h", op), cmd_start, 1'b0);
        bus_rd(3'd7, r); check($sformatf("R8 abort status %0h", op), r, 8'h51);
        bus_rd(3'd1, r); check($sformatf("R8 abort error %0h", op), r, 8'h04);
      end
    end

    // R7 SMART key from vector B0h/4F/C3 aborted above; R5 error cleared by next command
    bus_wr(3'd7, 8'h20);
    bus_rd(3'd7, r); check("R5 error cleared", r, 8'hD0);
    // R11 ignored writes and status reads while busy
    bus_wr(3'd2, 8'h77);
    bus_wr(3'd0, 8'h66);
    check("R11 no dp_wr busy", dp_wr, 1'b0);
    bus_wr(3'd7, 8'h00);
    check("R11 no restart", cmd_start, 1'b0);
    bus_rd(3'd2, r); check("R11 read gives status", r, 8'hD0);
    bus_rd(3'd6, r); check("R11 dh gives status", r, 8'hD0);
    finish_cmd(1'b0);
    bus_rd(3'd2, r); check("R11 sector count kept", r, 8'h08);
    check("R11 opcode kept", cmd_opcode, 8'h20);
    last_word();

    // R9 backend failure
    bus_wr(3'd7, 8'hC8);
    finish_cmd(1'b1);
    bus_rd(3'd7, r); check("R9 fail status", r, 8'h51);
    bus_rd(3'd1, r); check("R9 fail error", r, 8'h04);

    // R1 reset again restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(3'd7, r); check("R1 status after reset", r, 8'h50);
    bus_rd(3'd6, r); check("R1 dh after reset", r, 8'hA0);
    bus_rd(3'd2, r); check("R1 count after reset", r, 8'h00);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule